// File: doc/BRIEF.md
# Dual-Channel ADC Capture Front End

This block sits between a two-channel 10-bit converter and an existing sample stream. The converter presents both channels on one shared 10-bit parallel bus. Channel A is valid around the rising edge of the converter clock and channel B around the falling edge. The block latches each channel on the matching edge and places each result in the low bits of a 16-bit slot with zeroed upper bits. It then emits channel A followed by channel B as a valid/data stream, one slot per core cycle. This is the same stream a digital sampler produces, so downstream packing and memory-writing logic can take it without change.

Two clocking modes are selectable. In tracking mode an external converter clock arrives asynchronously. The block passes it and the data bus through matched two-stage synchronisers, and detects edges in the core clock domain. In generating mode the block drives the converter clock itself, with a 50% duty cycle and a programmable half period in core cycles. This mode sustains the full conversion rate on both channels. A sticky flag reports conversions that arrive faster than a pair can be drained.

Top module: `adc_pair_capture`

## Requirements
- R1: While reset is asserted, and on leaving it, `adcClkOut`, `sampleValid` and `missedEdge` are all low.
- R2: In tracking mode (`modeInternal`=0), channel A is the bus value that accompanies a rising edge of `adcClkIn`, and channel B is the value that accompanies the following falling edge. Each conversion produces exactly two stream beats on consecutive cycles, A first then B, and conversions leave the stream in arrival order.
- R3: Every output slot carries the 10-bit result in bits 9:0, and bits 15:10 are zero.
- R4: In tracking mode, channel A is presented on the fourth rising core-clock edge, counting the first edge at which `adcClkIn` is sampled low after a high phase. Channel B is presented on the edge after that.
- R5: In generating mode, `adcClkOut` toggles every `divHalf` core cycles, so the period is 2·`divHalf` cycles with a 50% duty cycle. A `divHalf` of 0 behaves as 1. In tracking mode `adcClkOut` is held low.
- R6: In generating mode, channel A is the `adcBus` value sampled at the core edge that drives `adcClkOut` high. Channel B is the value sampled at the edge that drives it low. A is presented on the core edge after that falling edge, and B on the next edge.
- R7: `missedEdge` is set when a rising converter-clock edge (detected in tracking mode, generated in generating mode) occurs within two core cycles of the preceding falling edge, before the previous pair has been fully emitted. Once set, it stays high until reset. With three or more cycles of spacing it stays low.
- R8: With no converter-clock edges, `sampleValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeInternal | input | 1 | 1: block generates the converter clock; 0: track `adcClkIn` |
| divHalf | input | 8 | Half period of the generated clock in core cycles (0 acts as 1) |
| adcClkIn | input | 1 | External asynchronous converter clock (tracking mode) |
| adcBus | input | 10 | Shared conversion data bus |
| adcClkOut | output | 1 | Generated converter clock (low in tracking mode) |
| sampleValid | output | 1 | Stream beat valid |
| sampleData | output | 16 | Zero-extended channel result |
| missedEdge | output | 1 | Sticky flag: conversion arrived before previous pair drained |

## Verification
The checks assume that `modeInternal` and `divHalf` change only while reset is held. They also assume that `adcClkIn` is low when reset is released. In tracking mode, `adcBus` must change only together with `adcClkIn` or while it is steady, so the matched synchroniser stages keep data and edge aligned. The stimulus switches bus and clock at the same instant, away from the core edge, and holds each phase for whole core cycles. In generating mode, the bench behaves like a converter: it changes the bus every cycle and derives the expected channel values from the bus value in force at each observed clock toggle.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  // Strobes handed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic captureA;   // latch the bus into the channel A holding register
    logic captureB;   // latch the bus into the channel B holding register
    logic emitA;      // present channel A on the stream this edge
    logic emitB;      // present channel B on the stream this edge
    logic useDirect;  // take the bus unsynchronised (generated clock)
  } cap_strobe_t;

  typedef enum logic [1:0] {
    EMIT_IDLE,
    EMIT_FIRST,
    EMIT_SECOND
  } emit_state_e;

endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeInternal,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             adcClkIn,
  output logic             adcClkOut,
  output logic             missedEdge,
  output cap_strobe_t      strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  // Synchroniser chain for the external converter clock.
  logic [SYNC_STAGES-1:0] clkSync;
  logic                   syncPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_clkSync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) clkSync[g] <= 1'b0;
          else       clkSync[g] <= adcClkIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) clkSync[g] <= 1'b0;
          else       clkSync[g] <= clkSync[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= clkSync[LAST];
  end

  logic extRise, extFall;
  assign extRise = clkSync[LAST] & ~syncPrev;
  assign extFall = ~clkSync[LAST] & syncPrev;

  // Generated clock: toggle every effective half period.
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] lastCount;
  logic             genClk;
  logic             tick;

  assign lastCount = (divHalf == '0) ? '0 : divHalf - 1'b1;
  assign tick      = modeInternal && (divCnt == lastCount);

  always_ff @(posedge clk) begin
    if (!rstN || !modeInternal) begin
      divCnt <= '0;
      genClk <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      genClk <= ~genClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign adcClkOut = genClk;

  logic intRise, intFall, riseEvt, fallEvt;
  assign intRise = tick & ~genClk;
  assign intFall = tick & genClk;
  assign riseEvt = modeInternal ? intRise : extRise;
  assign fallEvt = modeInternal ? intFall : extFall;

  // Emission sequencer: a falling edge completes a pair.
  emit_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (fallEvt) begin
      stateNext = EMIT_FIRST;
    end else begin
      unique case (state)
        EMIT_FIRST:  stateNext = EMIT_SECOND;
        EMIT_SECOND: stateNext = EMIT_IDLE;
        default:     stateNext = EMIT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= EMIT_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              missedEdge <= 1'b0;
    else if (riseEvt && state != EMIT_IDLE) missedEdge <= 1'b1;
  end

  always_comb begin
    strobe.captureA  = riseEvt;
    strobe.captureB  = fallEvt;
    strobe.emitA     = (state == EMIT_FIRST);
    strobe.emitB     = (state == EMIT_SECOND);
    strobe.useDirect = modeInternal;
  end

endmodule

// File: rtl/adc_cap_datapath.sv
module adc_cap_datapath
  import adc_cap_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int SLOT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADC_W-1:0]  adcBus,
  input  cap_strobe_t       strobe,
  output logic              sampleValid,
  output logic [SLOT_W-1:0] sampleData
);

  localparam int PAD_W = SLOT_W - ADC_W;

  // Bus pipeline matched in depth to the clock synchroniser.
  logic [ADC_W-1:0] busPipe [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_busPipe
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) busPipe[g] <= '0;
          else       busPipe[g] <= adcBus;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) busPipe[g] <= '0;
          else       busPipe[g] <= busPipe[g-1];
        end
      end
    end
  endgenerate

  logic [ADC_W-1:0] capBus;
  assign capBus = strobe.useDirect ? adcBus : busPipe[SYNC_STAGES-1];

  logic [ADC_W-1:0] chanA, chanB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanA <= '0;
      chanB <= '0;
    end else begin
      if (strobe.captureA) chanA <= capBus;
      if (strobe.captureB) chanB <= capBus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else begin
      sampleValid <= strobe.emitA | strobe.emitB;
      if (strobe.emitA)      sampleData <= {{PAD_W{1'b0}}, chanA};
      else if (strobe.emitB) sampleData <= {{PAD_W{1'b0}}, chanB};
    end
  end

endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_cap_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int SLOT_W      = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeInternal,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              adcClkIn,
  input  logic [ADC_W-1:0]  adcBus,
  output logic              adcClkOut,
  output logic              sampleValid,
  output logic [SLOT_W-1:0] sampleData,
  output logic              missedEdge
);

  cap_strobe_t strobe;

  adc_cap_ctrl #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeInternal (modeInternal),
    .divHalf      (divHalf),
    .adcClkIn     (adcClkIn),
    .adcClkOut    (adcClkOut),
    .missedEdge   (missedEdge),
    .strobe       (strobe)
  );

  adc_cap_datapath #(
    .ADC_W       (ADC_W),
    .SLOT_W      (SLOT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .adcBus      (adcBus),
    .strobe      (strobe),
    .sampleValid (sampleValid),
    .sampleData  (sampleData)
  );

endmodule

// File: rtl/adc_pair_capture_chk.sv
module adc_pair_capture_chk #(
  parameter int ADC_W  = 10,
  parameter int SLOT_W = 16,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeInternal,
  input logic [DIV_W-1:0]  divHalf,
  input logic              adcClkOut,
  input logic              sampleValid,
  input logic [SLOT_W-1:0] sampleData,
  input logic              missedEdge
);

  localparam int RUN_W = DIV_W + 2;

  logic [RUN_W-1:0] runLen;
  logic             lastClk;
  logic             seenToggle;
  logic [RUN_W-1:0] effHalf;

  assign effHalf = (divHalf == '0) ? RUN_W'(1) : RUN_W'(divHalf);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen     <= '0;
      lastClk    <= 1'b0;
      seenToggle <= 1'b0;
    end else begin
      lastClk <= adcClkOut;
      if (adcClkOut != lastClk) begin
        runLen     <= RUN_W'(1);
        seenToggle <= 1'b1;
      end else if (runLen != '1) begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  // R3: upper slot bits are zero whenever a beat is valid
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleData[SLOT_W-1:ADC_W] == '0));

  // R2: a beat that starts a burst is followed by its partner
  a_r2_pair_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !$past(sampleValid)) |=> sampleValid);

  // R5: generated clock held low in tracking mode
  a_r5_low_when_tracking: assert property (@(posedge clk) disable iff (!rstN)
    !modeInternal |=> !adcClkOut);

  // R5: each generated half period lasts the programmed number of cycles
  a_r5_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (modeInternal && seenToggle && adcClkOut != lastClk) |-> (runLen == effHalf));

  // R7: missed-edge flag is sticky
  a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rstN)
    missedEdge |=> missedEdge);

endmodule

bind adc_pair_capture adc_pair_capture_chk #(
  .ADC_W  (ADC_W),
  .SLOT_W (SLOT_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .modeInternal (modeInternal),
  .divHalf      (divHalf),
  .adcClkOut    (adcClkOut),
  .sampleValid  (sampleValid),
  .sampleData   (sampleData),
  .missedEdge   (missedEdge)
);

// File: tb/adc_pair_capture_bench.sv
module adc_pair_capture_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeInternal = 1'b0;
  logic [7:0]  divHalf = 8'd3;
  logic        adcClkIn = 1'b0;
  logic [9:0]  adcBus = '0;
  logic        adcClkOut;
  logic        sampleValid;
  logic [15:0] sampleData;
  logic        missedEdge;

  always #2 clk = ~clk;

  adc_pair_capture u_adc_pair_capture (
    .clk          (clk),
    .rstN         (rstN),
    .modeInternal (modeInternal),
    .divHalf      (divHalf),
    .adcClkIn     (adcClkIn),
    .adcBus       (adcBus),
    .adcClkOut    (adcClkOut),
    .sampleValid  (sampleValid),
    .sampleData   (sampleData),
    .missedEdge   (missedEdge)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit monOn   = 1'b0;
  string streamTag = "R2";
  logic [15:0] expQ [$];

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Stream monitor: every beat must match the next expected slot (R2/R6, R3).
  always @(negedge clk) begin
    if (monOn && sampleValid) begin
      check(sampleData[15:10] == 6'd0, "R3", sampleData[15:10], 0);
      if (expQ.size() == 0) begin
        check(1'b0, streamTag, sampleData, -1);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(sampleData == e, streamTag, sampleData, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic doReset(input bit mode, input logic [7:0] div);
    @(negedge clk);
    rstN = 1'b0;
    modeInternal = mode;
    divHalf = div;
    adcClkIn = 1'b0;
    adcBus = '0;
    expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One external conversion: A with rising edge, B with falling edge.
  task automatic extConv(input logic [9:0] a, input logic [9:0] b,
                         input int hi, input int lo);
    adcBus = a; adcClkIn = 1'b1; expQ.push_back({6'd0, a});
    repeat (hi) @(negedge clk);
    adcBus = b; adcClkIn = 1'b0; expQ.push_back({6'd0, b});
    repeat (lo) @(negedge clk);
  endtask

  task automatic runExternal(input int hi, input int lo, input int n);
    doReset(1'b0, 8'd3);
    streamTag = "R2";
    monOn = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [9:0] a, b;
      a = (i == 0) ? 10'd1023 : 10'((i * 341 + hi * 17 + lo * 5) % 1024);
      b = (i == 0) ? 10'd0    : 10'((i * 199 + hi * 3 + lo * 71) % 1024);
      extConv(a, b, hi, lo);
      check(adcClkOut == 1'b0, "R5", adcClkOut, 0);
    end
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R2", expQ.size(), 0);
    check(missedEdge == (lo <= 2), "R7", missedEdge, (lo <= 2));
    monOn = 1'b0;
  endtask

  task automatic runInternal(input logic [7:0] div, input int cycles);
    logic [9:0]  busDrv;
    logic        lastOut;
    logic [9:0]  pendA;
    int          runLen;
    bit          seen;
    int          eff;
    int          cyc;
    bit          done;
    eff = (div == 0) ? 1 : int'(div);
    doReset(1'b1, div);
    streamTag = "R6";
    monOn = 1'b1;
    busDrv = '0; lastOut = 1'b0; pendA = '0; runLen = 0; seen = 1'b0;
    cyc = 0; done = 1'b0;
    while (!done) begin
      logic o;
      @(negedge clk);
      o = adcClkOut;
      if (o != lastOut) begin
        if (seen) check(runLen == eff, "R5", runLen, eff);
        seen = 1'b1;
        runLen = 1;
        if (o) begin
          pendA = busDrv;
        end else begin
          expQ.push_back({6'd0, pendA});
          expQ.push_back({6'd0, busDrv});
          if (cyc >= cycles) begin
            modeInternal = 1'b0;
            done = 1'b1;
          end
        end
      end else begin
        runLen++;
      end
      lastOut = o;
      cyc++;
      busDrv = 10'((int'(busDrv) * 5 + int'(div) * 3 + 1) % 1024);
      adcBus = busDrv;
    end
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R6", expQ.size(), 0);
    check(adcClkOut == 1'b0, "R5", adcClkOut, 0);
    check(missedEdge == (eff <= 2), "R7", missedEdge, (eff <= 2));
    if (eff <= 2) begin
      repeat (20) @(negedge clk);
      check(missedEdge == 1'b1, "R7", missedEdge, 1);
    end
    monOn = 1'b0;
  endtask

  initial begin
    // R1: reset state, even with generating mode requested
    @(negedge clk);
    rstN = 1'b0; modeInternal = 1'b1; divHalf = 8'd1;
    repeat (4) @(negedge clk);
    check(adcClkOut == 1'b0,   "R1", adcClkOut, 0);
    check(sampleValid == 1'b0, "R1", sampleValid, 0);
    check(missedEdge == 1'b0,  "R1", missedEdge, 0);
    rstN = 1'b1;
    check(adcClkOut == 1'b0,   "R1", adcClkOut, 0);
    check(sampleValid == 1'b0, "R1", sampleValid, 0);

    // R4: exact latency in tracking mode
    doReset(1'b0, 8'd3);
    adcBus = 10'd5; adcClkIn = 1'b1;
    repeat (3) @(negedge clk);
    adcBus = 10'd9; adcClkIn = 1'b0;
    repeat (3) @(negedge clk);
    check(sampleValid == 1'b0, "R4", sampleValid, 0);
    @(negedge clk);
    check(sampleValid == 1'b1, "R4", sampleValid, 1);
    check(sampleData == 16'd5, "R4", sampleData, 5);
    @(negedge clk);
    check(sampleValid == 1'b1, "R4", sampleValid, 1);
    check(sampleData == 16'd9, "R4", sampleData, 9);
    @(negedge clk);
    check(sampleValid == 1'b0, "R4", sampleValid, 0);

    // R8: no edges, no output
    doReset(1'b0, 8'd3);
    adcBus = 10'd77;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(sampleValid == 1'b0, "R8", sampleValid, 0);
      if (i == 10) adcBus = 10'd300;
    end

    // R2, R3, R5, R7: tracking-mode sweep over phase lengths
    for (int hi = 1; hi <= 3; hi++)
      for (int lo = 1; lo <= 4; lo++)
        runExternal(hi, lo, 6);

    // R5, R6, R7: generating-mode sweep over divider settings
    for (int d = 0; d <= 6; d++)
      runInternal(8'(d), 60);

    finishRun();
  end

endmodule